// File: doc/BRIEF.md
# DMA Page Permission Gate

This block stands between device DMA traffic and memory. It enforces isolation only: it decides whether a request may proceed and passes the physical address through unchanged. Every device belongs to a protection domain. Each domain owns a flat bit vector in which one bit stands for one 4 KB physical page, and a set bit allows the domain to touch that page. A request carries a physical address, a byte length and a domain number. The gate works out every page that the byte range covers and grants the request only when all of their bits are set. Otherwise it blocks the request and raises a fault pulse.

The permission vectors live in on-chip storage. Software loads them through a write port that overwrites one 32-bit word of one domain's vector at a time. The full 4 GB map would need 1 M bits per domain. In this model the number of covered pages is a parameter, and pages beyond that range count as forbidden. The verdict is registered and appears a fixed two cycles after the request cycle. One request may be accepted every cycle.

Top module: `dmaperm_guard`

## Requirements
- R1: While reset is asserted and right after it, resp_valid and fault are low and every permission bit is cleared, so that any request is blocked until software writes a vector.
- R2: The page index is req_addr[31:12]. Bit b of permission word w of domain d governs page 32*w+b of that domain, and a 1 means access is allowed.
- R3: The pages checked run from req_addr[31:12] through (req_addr+req_len-1)[31:12]. The request is granted only if every one of them is allowed.
- R4: A request is judged only against the vector of its own req_dom. A write to one domain leaves the other domains' vectors unchanged.
- R5: A request presented with req_valid high in cycle c produces resp_valid high for exactly one cycle, in cycle c+2. Requests in consecutive cycles give responses in consecutive cycles.
- R6: fault is high in a response cycle exactly when the request is blocked, and it is never high outside a response cycle.
- R7: resp_addr and resp_dom return the request's address and domain unchanged.
- R8: A write with wr_en high replaces the whole addressed 32-bit word. It governs every request presented in a later cycle.
- R9: A page whose index is 2^IDX_W or more has no permission bit and is always blocked.
- R10: A request with req_len equal to 0, or one whose last byte lies beyond address 0xFFFFFFFF, is blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A DMA request is present this cycle |
| req_addr | input | 32 | Physical byte address of the request |
| req_len | input | LEN_W | Request length in bytes |
| req_dom | input | DOM_W | Protection domain of the requesting device |
| wr_en | input | 1 | Write one permission word |
| wr_dom | input | DOM_W | Domain whose vector is written |
| wr_word | input | IDX_W-5 | Word index within the vector |
| wr_data | input | 32 | New word value, bit b for page 32*wr_word+b |
| resp_valid | output | 1 | Verdict for the request of two cycles earlier |
| resp_grant | output | 1 | 1 = request may proceed |
| fault | output | 1 | Pulse: request blocked |
| resp_addr | output | 32 | Untranslated request address |
| resp_dom | output | DOM_W | Request domain |

## Verification
The assertions check timing and boundaries on every cycle. Each request gets its response two cycles later, and every response traces back to a request. The returned address matches the one presented. Zero-length requests, requests that wrap past 4 GB and requests to pages outside the table always fault. Only the bench scenarios can show that the verdict follows the loaded bit pattern. They cover spans of one, two and three pages, a single forbidden page inside a span, separation between domains, and a rewritten word taking effect on the next request.

// File: rtl/dmaperm_pkg.sv
package dmaperm_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int WORD_W     = 32;
    localparam int BIT_W      = 5;

    // Largest number of pages one request of up to 2^len_w-1 bytes can touch
    function automatic int span_max(input int len_w);
        return (((2 ** len_w) - 2 + (2 ** PAGE_SHIFT) - 1) >> PAGE_SHIFT) + 1;
    endfunction
endpackage

// File: rtl/dmaperm_span.sv
module dmaperm_span
    import dmaperm_pkg::*;
#(
    parameter int LEN_W = 13,
    parameter int CNT_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [PAGE_W-1:0] first_page,
    output logic [CNT_W-1:0]  npages,
    output logic              bad
);
    logic [ADDR_W:0]   last_byte;
    logic [PAGE_W-1:0] page_diff;

    always_comb begin
        last_byte  = {1'b0, addr} + (ADDR_W+1)'(len) - (ADDR_W+1)'(1);
        first_page = addr[ADDR_W-1:PAGE_SHIFT];
        page_diff  = last_byte[ADDR_W-1:PAGE_SHIFT] - first_page + PAGE_W'(1);
        npages     = CNT_W'(page_diff);
        // empty range, or the range runs off the top of the address space
        bad        = (len == '0) || last_byte[ADDR_W];
    end
endmodule

// File: rtl/dmaperm_table.sv
module dmaperm_table
    import dmaperm_pkg::*;
#(
    parameter int DOMS   = 2,
    parameter int IDX_W  = 10,
    parameter int NRD    = 3,
    parameter int DOM_W  = 1,
    localparam int WORDS  = (2 ** IDX_W) / WORD_W,
    localparam int WIDX_W = IDX_W - BIT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DOM_W-1:0]     wr_dom,
    input  logic [WIDX_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [DOM_W-1:0]     rd_dom,
    input  logic [PAGE_W-1:0]    rd_page [NRD],
    output logic [NRD-1:0]       rd_bit
);
    typedef logic [WORD_W-1:0] word_t;

    word_t mem_q [DOMS][WORDS];
    word_t mem_d [DOMS][WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_dom) < DOMS)) begin
            mem_d[wr_dom][wr_word] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DOMS; d++) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem_q[d][w] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        logic              in_range;
        logic              dom_ok;
        logic [WIDX_W-1:0] widx;
        logic [BIT_W-1:0]  bidx;
        always_comb begin
            in_range  = (({{ADDR_W-PAGE_W{1'b0}}, rd_page[k]} >> IDX_W) == '0);
            dom_ok    = (int'(rd_dom) < DOMS);
            widx      = rd_page[k][IDX_W-1:BIT_W];
            bidx      = rd_page[k][BIT_W-1:0];
            rd_bit[k] = in_range && dom_ok && mem_q[rd_dom][widx][bidx];
        end
    end
endmodule

// File: rtl/dmaperm_verdict.sv
module dmaperm_verdict #(
    parameter int NRD   = 3,
    parameter int CNT_W = 2
) (
    input  logic             vld,
    input  logic             bad,
    input  logic [CNT_W-1:0] npages,
    input  logic [NRD-1:0]   bits,
    output logic             grant
);
    logic all_set;

    always_comb begin
        all_set = 1'b1;
        for (int k = 0; k < NRD; k++) begin
            if ((CNT_W'(k) < npages) && !bits[k]) begin
                all_set = 1'b0;
            end
        end
        grant = vld && !bad && all_set;
    end
endmodule

// File: rtl/dmaperm_guard.sv
module dmaperm_guard
    import dmaperm_pkg::*;
#(
    parameter int DOMS  = 2,
    parameter int IDX_W = 10,
    parameter int LEN_W = 13,
    localparam int DOM_W    = (DOMS > 1) ? $clog2(DOMS) : 1,
    localparam int WIDX_W   = IDX_W - BIT_W,
    localparam int MAX_SPAN = span_max(LEN_W),
    localparam int CNT_W    = $clog2(MAX_SPAN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DOM_W-1:0]  req_dom,
    input  logic              wr_en,
    input  logic [DOM_W-1:0]  wr_dom,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [31:0]       wr_data,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              fault,
    output logic [31:0]       resp_addr,
    output logic [DOM_W-1:0]  resp_dom
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DOM_W-1:0]  dom;
        logic [PAGE_W-1:0] first;
        logic [CNT_W-1:0]  npages;
        logic              bad;
    } look_t;

    typedef struct packed {
        logic              vld;
        logic              grant;
        logic [ADDR_W-1:0] addr;
        logic [DOM_W-1:0]  dom;
    } resp_t;

    look_t look_d, look_q;
    resp_t resp_d, resp_q;

    logic [PAGE_W-1:0] sp_first;
    logic [CNT_W-1:0]  sp_npages;
    logic              sp_bad;
    logic [PAGE_W-1:0] pg [MAX_SPAN];
    logic [MAX_SPAN-1:0] pg_bit;
    logic              verdict;

    dmaperm_span #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_span (
        .addr       (req_addr),
        .len        (req_len),
        .first_page (sp_first),
        .npages     (sp_npages),
        .bad        (sp_bad)
    );

    for (genvar k = 0; k < MAX_SPAN; k++) begin : g_pg
        always_comb pg[k] = look_q.first + PAGE_W'(k);
    end

    dmaperm_table #(.DOMS(DOMS), .IDX_W(IDX_W), .NRD(MAX_SPAN), .DOM_W(DOM_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_dom  (wr_dom),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .rd_dom  (look_q.dom),
        .rd_page (pg),
        .rd_bit  (pg_bit)
    );

    dmaperm_verdict #(.NRD(MAX_SPAN), .CNT_W(CNT_W)) u_verdict (
        .vld    (look_q.vld),
        .bad    (look_q.bad),
        .npages (look_q.npages),
        .bits   (pg_bit),
        .grant  (verdict)
    );

    always_comb begin
        look_d.vld    = req_valid;
        look_d.addr   = req_addr;
        look_d.dom    = req_dom;
        look_d.first  = sp_first;
        look_d.npages = sp_npages;
        look_d.bad    = sp_bad;

        resp_d.vld    = look_q.vld;
        resp_d.grant  = verdict;
        resp_d.addr   = look_q.addr;
        resp_d.dom    = look_q.dom;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_q <= '0;
            resp_q <= '0;
        end else begin
            look_q <= look_d;
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.vld;
    assign resp_grant = resp_q.grant;
    assign fault      = resp_q.vld && !resp_q.grant;
    assign resp_addr  = resp_q.addr;
    assign resp_dom   = resp_q.dom;
endmodule

// File: rtl/dmaperm_guard_chk.sv
module dmaperm_guard_chk #(
    parameter int IDX_W = 10,
    parameter int LEN_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_addr,
    input logic [LEN_W-1:0] req_len,
    input logic             resp_valid,
    input logic             resp_grant,
    input logic             fault,
    input logic [31:0]      resp_addr
);
    logic [32:0] end_byte;
    assign end_byte = {1'b0, req_addr} + 33'(req_len) - 33'd1;

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 resp_valid);

    assert_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid, 2));

    assert_addr_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_addr == $past(req_addr, 2)));

    assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len == '0) |-> ##2 (fault && !resp_grant));

    assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && end_byte[32]) |-> ##2 (fault && !resp_grant));

    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (({12'd0, req_addr[31:12]} >> IDX_W) != 0)) |-> ##2 fault);

    assert_fault_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(req_valid, 2));
endmodule

bind dmaperm_guard dmaperm_guard_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .resp_valid (resp_valid),
    .resp_grant (resp_grant),
    .fault      (fault),
    .resp_addr  (resp_addr)
);

// File: tb/dmaperm_guard_test.sv
module dmaperm_guard_test;
    localparam int PERIOD = 10;
    localparam int LEN_W  = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic        req_dom = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_dom = 1'b0;
    logic [4:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic        resp_valid, resp_grant, fault, resp_dom;
    logic [31:0] resp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dmaperm_guard #(.DOMS(2), .IDX_W(10), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_dom(req_dom), .wr_en(wr_en), .wr_dom(wr_dom),
        .wr_word(wr_word), .wr_data(wr_data), .resp_valid(resp_valid),
        .resp_grant(resp_grant), .fault(fault), .resp_addr(resp_addr),
        .resp_dom(resp_dom)
    );

    typedef struct packed {
        logic             dom;
        logic [31:0]      addr;
        logic [LEN_W-1:0] len;
        logic             grant;
    } vec_t;

    // dom0: pages 0-3, 32, 63, 1023 allowed; dom1: pages 4-7 allowed
    localparam vec_t VECS [17] = '{
        '{1'b0, 32'h0000_0000, 13'd4,     1'b1},  // R2 single page
        '{1'b0, 32'h0000_3FF0, 13'h0020,  1'b0},  // R3 page 4 not in dom0
        '{1'b0, 32'h0000_1000, 13'h1FFF,  1'b1},  // R3 pages 1-2
        '{1'b0, 32'h0000_0FFF, 13'd2,     1'b1},  // R3 crosses 0->1
        '{1'b0, 32'h0000_4000, 13'd1,     1'b0},  // R4 dom1 page seen from dom0
        '{1'b1, 32'h0000_4000, 13'd1,     1'b1},  // R4 dom1 own page
        '{1'b1, 32'h0000_3FFF, 13'd2,     1'b0},  // R4 page 3 not in dom1
        '{1'b0, 32'h0002_0000, 13'h1000,  1'b1},  // R2 page 32 whole
        '{1'b0, 32'h0002_0FFF, 13'd2,     1'b0},  // R3 page 33 clear
        '{1'b0, 32'h003F_F000, 13'h1000,  1'b1},  // R2 last page 1023
        '{1'b0, 32'h003F_FFFF, 13'd2,     1'b0},  // R9 runs into page 1024
        '{1'b0, 32'h0040_0000, 13'd1,     1'b0},  // R9 page 1024
        '{1'b0, 32'h0000_0000, 13'd0,     1'b0},  // R10 zero length
        '{1'b0, 32'hFFFF_F000, 13'h1001,  1'b0},  // R10 wraps past 4 GB
        '{1'b1, 32'h0000_5000, 13'h1FFF,  1'b1},  // R3 pages 5-6
        '{1'b1, 32'h0000_6800, 13'h1FFF,  1'b0},  // R3 pages 6-8, 8 clear
        '{1'b1, 32'h0000_5800, 13'h1FFF,  1'b1}   // R3 three pages 5-7
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic d, input logic [4:0] w, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_dom = d; wr_word = w; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic d, input logic [31:0] a, input logic [LEN_W-1:0] l,
                        input logic exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_dom = d; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(resp_valid === 1'b1, {req, " R5 resp_valid"}, 32'(resp_valid), 32'd1);
        check(resp_grant === exp, {req, " grant"}, 32'(resp_grant), 32'(exp));
        check(fault === !exp, {req, " R6 fault"}, 32'(fault), 32'(!exp));
        check(resp_addr === a && resp_dom === d, {req, " R7 addr"}, resp_addr, a);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(resp_valid === 1'b0 && fault === 1'b0, "R1 outputs in reset",
              {30'd0, resp_valid, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid === 1'b0 && fault === 1'b0, "R1 outputs after reset",
              {30'd0, resp_valid, fault}, 32'd0);
        send(1'b0, 32'h0000_0000, 13'd4, 1'b0, "R1 cleared table");

        wr(1'b0, 5'd0, 32'h0000_000F);
        wr(1'b0, 5'd1, 32'h8000_0001);
        wr(1'b0, 5'd31, 32'h8000_0000);
        wr(1'b1, 5'd0, 32'h0000_00F0);

        for (int i = 0; i < 17; i++) begin
            send(VECS[i].dom, VECS[i].addr, VECS[i].len, VECS[i].grant,
                 $sformatf("vec%0d", i));
        end

        // R6 fault is a single-cycle pulse
        send(1'b0, 32'h0000_4000, 13'd1, 1'b0, "R6 pulse");
        @(negedge clk);
        check(fault === 1'b0 && resp_valid === 1'b0, "R6 fault drops",
              {30'd0, resp_valid, fault}, 32'd0);

        // R5 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_dom = 1'b0; req_addr = 32'h0000_0000; req_len = 13'd1;
        @(negedge clk);
        req_addr = 32'h0000_4000;
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid === 1'b1 && resp_grant === 1'b1, "R5 first of pair",
              {30'd0, resp_valid, resp_grant}, 32'd3);
        @(negedge clk);
        check(resp_valid === 1'b1 && resp_grant === 1'b0 && resp_addr === 32'h0000_4000,
              "R5 second of pair", resp_addr, 32'h0000_4000);
        @(negedge clk);
        check(resp_valid === 1'b0, "R5 single response each", 32'(resp_valid), 32'd0);

        // R8 overwrite takes effect; R4 other domain untouched
        wr(1'b0, 5'd0, 32'h0000_0000);
        send(1'b0, 32'h0000_0000, 13'd1, 1'b0, "R8 cleared word");
        send(1'b1, 32'h0000_4000, 13'd1, 1'b1, "R4 dom1 kept");
        wr(1'b0, 5'd0, 32'h0000_0010);
        send(1'b0, 32'h0000_4000, 13'd1, 1'b1, "R8 new bit");
        send(1'b0, 32'h0000_1000, 13'd1, 1'b0, "R8 whole word replaced");

        // R1 reset clears the table again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        send(1'b1, 32'h0000_4000, 13'd1, 1'b0, "R1 reset clears");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule